// File: doc/BRIEF.md
# FIFO with Distinct-Value Counter

A single-clock first-in first-out buffer of 32 words of 32 bits. Besides the usual storage and full/empty status, it keeps a live count of how many different values are held at present. When that count reaches a threshold set at elaboration time, it raises a flag. The flag can be used to spot a stream that has become too varied, or too repetitive, while it is still buffered.

Each push compares the incoming word against every resident entry in parallel. Each pop compares the departing word against every other resident entry. With these two comparisons the count stays exact when duplicates are present. The read port is show-ahead: the oldest word is on `rdata_o` whenever the FIFO is not empty, and a pop consumes it.

Top module: `fifo_distinct`

## Requirements
- R1: Words leave in the order they were pushed. Whenever `empty_o` is 0, `rdata_o` shows the oldest resident word.
- R2: The FIFO holds `DEPTH` (32) words. `full_o` is 1 exactly when 32 words are resident, and `empty_o` is 1 exactly when none are.
- R3: A push while `full_o` is 1 is ignored. If it comes together with a pop, only the pop takes place.
- R4: A pop while `empty_o` is 1 changes neither the contents nor `count_o`. If it comes together with a push, only the push takes place.
- R5: An accepted push raises `count_o` by one only when no resident word holds the same value.
- R6: An accepted pop lowers `count_o` by one only when no other resident word holds the popped value, and that value is not pushed in the same cycle.
- R7: When a push and a pop are both accepted in one cycle, `count_o` changes by the sum of their two effects. A value that is pushed and popped in the same cycle counts as still present.
- R8: `flag_o` is 1 exactly when `count_o` is at least `THRESH` (default 7). It is registered and changes on the same clock edge as `count_o`.
- R9: Asserting `rst_ni` low empties the FIFO and clears `count_o` and `flag_o`.
- R10: `count_o` is 0 exactly when the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Write request |
| wdata_i | input | WIDTH | Word to write |
| pop_i | input | 1 | Read request; consumes the word on rdata_o |
| rdata_o | output | WIDTH | Oldest resident word (show-ahead) |
| full_o | output | 1 | FIFO holds DEPTH words |
| empty_o | output | 1 | FIFO holds no words |
| count_o | output | $clog2(DEPTH+1) | Number of distinct resident values |
| flag_o | output | 1 | count_o has reached THRESH |

## Verification
The first pattern pushes a rising run of distinct values. It exercises the increment path alone and the point where the flag turns on. Repeated values then separate a push that must leave the count unchanged from one that raises it. Pops then separate removing the last copy of a value from removing one of several copies. Cycles that push and pop the same value, or two different values, test the combined update. Filling and draining with a small alphabet exercises the full and empty edges and the ignored operations there. A long random run over ten values then mixes all of these cases against the behavioural model.

// File: rtl/fifo_distinct_pkg.sv
package fifo_distinct_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'b00,
    CNT_INC  = 2'b01,
    CNT_DEC  = 2'b10
  } cnt_op_e;
endpackage

// File: rtl/fifo_distinct_store.sv
module fifo_distinct_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        push_ok_i,
  input  logic                        pop_ok_i,
  input  logic [WIDTH-1:0]            wdata_i,
  output logic [DEPTH-1:0][WIDTH-1:0] mem_o,
  output logic [DEPTH-1:0]            vld_o,
  output logic [PW-1:0]               rptr_o,
  output logic [LW-1:0]               level_o
);
  logic [DEPTH-1:0][WIDTH-1:0] mem_q;
  logic [DEPTH-1:0]            vld_q;
  logic [PW-1:0]               wptr_q, rptr_q;
  logic [LW-1:0]               level_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push_ok_i) wptr_q <= ptr_inc(wptr_q);
      if (pop_ok_i)  rptr_q <= ptr_inc(rptr_q);
      if (push_ok_i && !pop_ok_i)      level_q <= level_q + 1'b1;
      else if (pop_ok_i && !push_ok_i) level_q <= level_q - 1'b1;
    end
  end

  // data array is not reset; validity is carried by vld_q
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic wr_hit, rd_hit;
    assign wr_hit = push_ok_i && (wptr_q == PW'(i));
    assign rd_hit = pop_ok_i  && (rptr_q == PW'(i));

    always_ff @(posedge clk_i) begin
      if (wr_hit) mem_q[i] <= wdata_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     vld_q[i] <= 1'b0;
      else if (wr_hit) vld_q[i] <= 1'b1;
      else if (rd_hit) vld_q[i] <= 1'b0;
    end
  end

  assign mem_o   = mem_q;
  assign vld_o   = vld_q;
  assign rptr_o  = rptr_q;
  assign level_o = level_q;
endmodule

// File: rtl/fifo_distinct_match.sv
module fifo_distinct_match #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]            key_i,
  input  logic [DEPTH-1:0][WIDTH-1:0] mem_i,
  input  logic [DEPTH-1:0]            mask_i,
  output logic                        hit_o
);
  logic [DEPTH-1:0] eq;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign eq[i] = mask_i[i] && (mem_i[i] == key_i);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/fifo_distinct_count.sv
module fifo_distinct_count
  import fifo_distinct_pkg::*;
#(
  parameter int unsigned CW     = 6,
  parameter int unsigned THRESH = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o,
  output logic          flag_o
);
  cnt_op_e       op;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q;

  always_comb begin
    unique case ({dec_i, inc_i})
      2'b01:   op = CNT_INC;
      2'b10:   op = CNT_DEC;
      default: op = CNT_HOLD; // inc and dec cancel
    endcase
  end

  always_comb begin
    unique case (op)
      CNT_INC: cnt_d = cnt_q + 1'b1;
      CNT_DEC: cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= (32'(cnt_d) >= THRESH);
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/fifo_distinct.sv
module fifo_distinct #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned THRESH = 7,
  localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW    = $clog2(DEPTH + 1),
  localparam int unsigned CW    = LW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CW-1:0]    count_o,
  output logic             flag_o
);
  logic [DEPTH-1:0][WIDTH-1:0] mem;
  logic [DEPTH-1:0]            vld, rsel, others;
  logic [PW-1:0]               rptr;
  logic [LW-1:0]               level;
  logic push_ok, pop_ok, hit_w, hit_r, same, inc, dec;

  assign full_o  = (level == LW'(DEPTH));
  assign empty_o = (level == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i  && !empty_o;

  fifo_distinct_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_ok_i(push_ok),
    .pop_ok_i (pop_ok),
    .wdata_i  (wdata_i),
    .mem_o    (mem),
    .vld_o    (vld),
    .rptr_o   (rptr),
    .level_o  (level)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_rsel
    assign rsel[i] = (rptr == PW'(i));
  end
  assign others  = vld & ~rsel;
  assign rdata_o = mem[rptr];

  // incoming word against all resident entries
  fifo_distinct_match #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_match_w (
    .key_i (wdata_i),
    .mem_i (mem),
    .mask_i(vld),
    .hit_o (hit_w)
  );

  // head word against every other resident entry
  fifo_distinct_match #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_match_r (
    .key_i (rdata_o),
    .mem_i (mem),
    .mask_i(others),
    .hit_o (hit_r)
  );

  assign same = push_ok && (wdata_i == rdata_o);
  assign inc  = push_ok && !hit_w;
  assign dec  = pop_ok && !hit_r && !same;

  fifo_distinct_count #(.CW(CW), .THRESH(THRESH)) u_count (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc),
    .dec_i (dec),
    .cnt_o (count_o),
    .flag_o(flag_o)
  );
endmodule

// File: rtl/fifo_distinct_chk.sv
module fifo_distinct_chk #(
  parameter int unsigned THRESH = 7,
  parameter int unsigned CW     = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic          full_o,
  input logic          empty_o,
  input logic [CW-1:0] count_o,
  input logic          flag_o
);
  a_r2_full_empty_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  a_r10_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> count_o == '0);

  a_r10_nonempty_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_o |-> count_o != '0);

  a_r8_flag_thresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o == (32'(count_o) >= THRESH));

  a_r4_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i |=> empty_o && count_o == '0);

  a_r3_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o && $stable(count_o));

  a_r5_push_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i && !full_o |=>
      (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));

  a_r6_pop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !push_i && !empty_o |=>
      (count_o == $past(count_o)) || (count_o == $past(count_o) - 1'b1));
endmodule

bind fifo_distinct fifo_distinct_chk #(.THRESH(THRESH), .CW(CW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .push_i (push_i),
  .pop_i  (pop_i),
  .full_o (full_o),
  .empty_o(empty_o),
  .count_o(count_o),
  .flag_o (flag_o)
);

// File: tb/fifo_distinct_tb.sv
module fifo_distinct_tb;
  localparam int DEPTH  = 32;
  localparam int WIDTH  = 32;
  localparam int THRESH = 7;
  localparam int CW     = $clog2(DEPTH + 1);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             push_i = 1'b0, pop_i = 1'b0;
  logic [WIDTH-1:0] wdata_i = '0;
  logic [WIDTH-1:0] rdata_o;
  logic             full_o, empty_o, flag_o;
  logic [CW-1:0]    count_o;

  int checks = 0, errors = 0;
  logic [WIDTH-1:0] q[$];

  always #5 clk_i = ~clk_i;

  fifo_distinct #(.DEPTH(DEPTH), .WIDTH(WIDTH), .THRESH(THRESH)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .wdata_i(wdata_i),
    .pop_i(pop_i), .rdata_o(rdata_o), .full_o(full_o), .empty_o(empty_o),
    .count_o(count_o), .flag_o(flag_o)
  );

  function automatic int distinct();
    int n = 0;
    for (int i = 0; i < q.size(); i++) begin
      bit seen = 0;
      for (int j = 0; j < i; j++) if (q[j] == q[i]) seen = 1;
      if (!seen) n++;
    end
    return n;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int d = distinct();
    chk("R2", "empty_o", 32'(empty_o), 32'(q.size() == 0));
    chk("R2", "full_o", 32'(full_o), 32'(q.size() == DEPTH));
    chk(tag, "count_o", 32'(count_o), d);
    chk("R8", "flag_o", 32'(flag_o), 32'(d >= THRESH));
    chk("R10", "count zero iff empty", 32'(count_o == 0), 32'(empty_o));
    if (q.size() != 0) chk("R1", "rdata_o", rdata_o, q[0]);
  endtask

  // drive between edges, model the edge, sample 2 ns after it
  task automatic step(bit ps, bit pp, logic [31:0] d, string tag);
    bit pok, wok;
    push_i = ps; pop_i = pp; wdata_i = d;
    wok = ps && (q.size() < DEPTH);
    pok = pp && (q.size() > 0);
    @(posedge clk_i);
    if (pok) void'(q.pop_front());
    if (wok) q.push_back(d);
    #2;
    push_i = 1'b0; pop_i = 1'b0;
    compare(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    q.delete();
    repeat (2) @(posedge clk_i);
    #2;
    chk("R9", "empty_o in reset", 32'(empty_o), 32'd1);
    chk("R9", "count_o in reset", 32'(count_o), 32'd0);
    chk("R9", "flag_o in reset", 32'(flag_o), 32'd0);
    chk("R9", "full_o in reset", 32'(full_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R5: distinct run reaches threshold, then duplicates hold the count
    for (int v = 1; v <= 7; v++) step(1, 0, 32'(v), "R5");
    chk("R8", "flag after 7 distinct", 32'(flag_o), 32'd1);
    step(1, 0, 32'd3, "R5");
    step(1, 0, 32'd3, "R5");
    chk("R5", "duplicate push holds count", 32'(count_o), 32'd7);
    // R6: last copies leave, then one of several copies leaves
    step(0, 1, 0, "R6");
    step(0, 1, 0, "R6");
    chk("R8", "flag clears below threshold", 32'(flag_o), 32'd0);
    step(0, 1, 0, "R6");
    chk("R6", "popping one of three copies", 32'(count_o), 32'd5);
    // R7: push head value while popping it, then differing values
    step(1, 1, q[0], "R7");
    step(1, 1, 32'd42, "R7");
    step(1, 1, 32'd42, "R7");
    // fill with a small alphabet, then R3 on full
    while (q.size() < DEPTH) step(1, 0, 32'(q.size() % 5), "R5");
    step(1, 0, 32'd99, "R3");
    step(1, 1, 32'd77, "R3");
    chk("R3", "push on full ignored with pop", 32'(q.size()), 32'(DEPTH - 1));
    // drain, then R4 on empty
    while (q.size() > 0) step(0, 1, 0, "R6");
    step(0, 1, 0, "R4");
    step(0, 1, 0, "R4");
    step(1, 1, 32'd5, "R4");
    chk("R4", "push with pop on empty", 32'(count_o), 32'd1);
    // mixed random traffic over a narrow value range
    for (int n = 0; n < 4000; n++) begin
      bit ps = ($urandom_range(0, 99) < 55);
      bit pp = ($urandom_range(0, 99) < 45);
      step(ps, pp, 32'($urandom_range(0, 9)), "R7");
    end
    // R9: reset while holding data
    do_reset();
    step(0, 1, 0, "R9");
    finish_run();
  end
endmodule